// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This controller brings a switchable logic domain up or down through a fixed, timed series of steps. It drives the domain's isolation clamp, the main power-switch control, the power-down controls of the domain's memories, a domain reset and two clock enables. One start pulse requests power-on and another requests power-off. While a sequence runs, `busy` is high. A one-cycle `done` pulse marks the end of each request, and `powered` follows the power-switch control.

The memories are handled as 32-bit power-down banks followed by an 8-bit auxiliary group. The banks change two adjacent bits per step, and the auxiliary group changes one bit per step. Every step is followed by a settling wait. A mode input, sampled when a sequence starts, selects two banks or three banks. All delays are counted in microsecond ticks. The tick comes from a prescaler derived from the `CLK_FREQ_HZ` parameter, and a single down-counter is reloaded for each wait.

Top module: `pwr_domain_seq`

## Requirements
- R1: In reset, the outputs hold the unpowered state: `iso_en`=1, `sw_on`=0, `dom_rst`=0, both clock enables 0, every `mem_pd` and `mem_pd_aux` bit 1, and `busy`=`done`=0. If `pwr_init` is 1 at the first clock edge after reset, that edge sets `sw_on`=1, `iso_en`=0, all memory bits 0 and both clock enables 1.
- R2: On a power-off start edge, `iso_en` and `busy` go to 1 on that edge. The first memory step follows exactly 20 µs later.
- R3: A 32-bit bank changes in 16 steps. Step p writes bits 2p and 2p+1 of the bank, starting at p=0, and steps are exactly 5 µs apart. Bank k occupies `mem_pd[32k+31:32k]`, and banks are processed in ascending k.
- R4: `mode_ext`=0 processes banks 0 and 1 only, leaving bank 2 unchanged. `mode_ext`=1 processes banks 0, 1 and 2. The mode is sampled only at the start edge.
- R5: After the banks, `mem_pd_aux` bits 0 through 7 change one bit per step in ascending order, 5 µs apart, continuing the same step spacing.
- R6: At power-off, `sw_on` falls 25 µs after the last auxiliary step, and `clka_en` falls 20 ms after that. On the following edge, `clkb_en` falls, `busy` drops and `done` pulses.
- R7: On a power-on start edge, `sw_on` and `busy` rise on that edge. 20 µs later the memory bits are cleared to 0 in the order of R3–R5, using the same spacing.
- R8: At power-on, `dom_rst` rises 25 µs after the last auxiliary step. It is followed on consecutive edges by `iso_en` falling, `dom_rst` falling, `clka_en` rising, and `clkb_en` rising together with `busy` dropping and `done` pulsing.
- R9: `powered` equals `sw_on` at all times.
- R10: Start pulses that arrive while `busy` is 1 have no effect on any output.
- R11: A request for the state the domain is already in gives a one-cycle `done` pulse on the start edge and changes no other output.
- R12: One microsecond is `CLK_FREQ_HZ`/1,000,000 clock cycles, and every wait is measured exactly from the edge of the preceding action.
- R13: If both start pulses arrive together while idle, power-off takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_init | input | 1 | Domain already powered; sampled at the first edge after reset |
| mode_ext | input | 1 | 1 selects three memory banks, 0 selects two |
| start_on | input | 1 | Power-on request pulse |
| start_off | input | 1 | Power-off request pulse |
| iso_en | output | 1 | Isolation clamp enable, active high |
| sw_on | output | 1 | Main power-switch control, 1 = domain supplied |
| dom_rst | output | 1 | Domain reset, active high |
| clka_en | output | 1 | First clock enable |
| clkb_en | output | 1 | Second clock enable |
| mem_pd | output | 96 | Bank memory power-down bits, 1 = powered down |
| mem_pd_aux | output | 8 | Auxiliary memory power-down bits, 1 = powered down |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| powered | output | 1 | Domain power status |

## Verification
The bench builds the block with `CLK_FREQ_HZ` = 2,000,000, so each microsecond spans two cycles. This setting exercises the prescaler wrap while keeping the full 20 ms switch-off wait short enough to run in both modes. With a cycle-exact expected timeline, any skipped, reordered or mistimed memory step, and any off-by-one in the tick or wait counters, appears as a mismatch at a precise cycle. A second reset with `pwr_init` high brings the already-powered start-up path within reach.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_LEAD_W,
        ST_MEM_W,
        ST_TAIL_W,
        ST_SWOFF_W,
        ST_CLKB_OFF,
        ST_ON_ISO,
        ST_ON_UNRST,
        ST_ON_CLKA,
        ST_ON_CLKB
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       going_on;
        logic       ext;
        logic       iso;
        logic       sw;
        logic       rst;
        logic       clka;
        logic       clkb;
        logic       busy;
        logic       done;
    } seq_regs_t;

endpackage

// File: rtl/pds_us_timer.sv
module pds_us_timer #(
    parameter int CLK_FREQ_HZ = 24_000_000,
    parameter int CNT_W       = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam int DIV = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [PW-1:0]    presc;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick;

    assign tick    = (tmr_q.presc == PW'(DIV - 1));
    assign expired = tick && (tmr_q.cnt == CNT_W'(1));

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.presc = '0;
            tmr_d.cnt   = load_val;
        end else begin
            tmr_d.presc = tick ? '0 : tmr_q.presc + PW'(1);
            if (tick && tmr_q.cnt != '0) begin
                tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/pds_mem_stepper.sv
module pds_mem_stepper #(
    parameter int BANK_W     = 32,
    parameter int AUX_W      = 8,
    parameter int BASE_BANKS = 2,
    parameter int EXT_BANKS  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init_en,
    input  logic                        init_val,
    input  logic                        rewind,
    input  logic                        step,
    input  logic                        set_val,
    input  logic                        ext,
    output logic [EXT_BANKS*BANK_W-1:0] pd,
    output logic [AUX_W-1:0]            aux,
    output logic                        all_done
);
    localparam int PAIR_W  = 2;
    localparam int PD_W    = EXT_BANKS * BANK_W;
    localparam int PAIRS   = BANK_W / PAIR_W;
    localparam int GRP_MAX = EXT_BANKS * PAIRS + AUX_W;
    localparam int GW      = $clog2(GRP_MAX + 1);

    typedef struct packed {
        logic [PD_W-1:0]  pd;
        logic [AUX_W-1:0] aux;
        logic [GW-1:0]    grp;
    } stp_t;

    stp_t stp_d, stp_q;
    logic [GW-1:0] bank_grps;

    assign bank_grps = ext ? GW'(EXT_BANKS * PAIRS) : GW'(BASE_BANKS * PAIRS);
    assign all_done  = (stp_q.grp == bank_grps + GW'(AUX_W));
    assign pd        = stp_q.pd;
    assign aux       = stp_q.aux;

    always_comb begin
        stp_d = stp_q;
        if (rewind) begin
            stp_d.grp = '0;
        end
        if (init_en) begin
            stp_d.pd  = {PD_W{init_val}};
            stp_d.aux = {AUX_W{init_val}};
        end else if (step) begin
            for (int j = 0; j < PD_W; j++) begin
                if (GW'(j / PAIR_W) == stp_q.grp && stp_q.grp < bank_grps) begin
                    stp_d.pd[j] = set_val;
                end
            end
            for (int k = 0; k < AUX_W; k++) begin
                if (stp_q.grp == bank_grps + GW'(k)) begin
                    stp_d.aux[k] = set_val;
                end
            end
            stp_d.grp = stp_q.grp + GW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stp_q.pd  <= '1;
            stp_q.aux <= '1;
            stp_q.grp <= '0;
        end else begin
            stp_q <= stp_d;
        end
    end
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
    parameter int CLK_FREQ_HZ  = 24_000_000,
    parameter int BANK_W       = 32,
    parameter int AUX_W        = 8,
    parameter int BASE_BANKS   = 2,
    parameter int EXT_BANKS    = 3,
    parameter int LEAD_US      = 20,
    parameter int STEP_US      = 5,
    parameter int TAIL_US      = 20,
    parameter int SW_SETTLE_US = 20_000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_init,
    input  logic                        mode_ext,
    input  logic                        start_on,
    input  logic                        start_off,
    output logic                        iso_en,
    output logic                        sw_on,
    output logic                        dom_rst,
    output logic                        clka_en,
    output logic                        clkb_en,
    output logic [EXT_BANKS*BANK_W-1:0] mem_pd,
    output logic [AUX_W-1:0]            mem_pd_aux,
    output logic                        busy,
    output logic                        done,
    output logic                        powered
);
    import pds_pkg::*;

    localparam int PD_W   = EXT_BANKS * BANK_W;
    localparam int MAX_A  = (LEAD_US > STEP_US) ? LEAD_US : STEP_US;
    localparam int MAX_B  = (TAIL_US > SW_SETTLE_US) ? TAIL_US : SW_SETTLE_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_US + 1);

    seq_regs_t        seq_d, seq_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_exp;
    logic             m_init, m_init_val, m_rewind, m_step, m_all_done;

    pds_us_timer #(
        .CLK_FREQ_HZ (CLK_FREQ_HZ),
        .CNT_W       (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    pds_mem_stepper #(
        .BANK_W     (BANK_W),
        .AUX_W      (AUX_W),
        .BASE_BANKS (BASE_BANKS),
        .EXT_BANKS  (EXT_BANKS)
    ) stepper_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (m_init),
        .init_val (m_init_val),
        .rewind   (m_rewind),
        .step     (m_step),
        .set_val  (!seq_q.going_on),
        .ext      (seq_q.ext),
        .pd       (mem_pd),
        .aux      (mem_pd_aux),
        .all_done (m_all_done)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;
        m_init     = 1'b0;
        m_init_val = 1'b0;
        m_rewind   = 1'b0;
        m_step     = 1'b0;
        case (seq_q.st)
            ST_INIT: begin
                if (pwr_init) begin
                    seq_d.sw   = 1'b1;
                    seq_d.iso  = 1'b0;
                    seq_d.clka = 1'b1;
                    seq_d.clkb = 1'b1;
                    m_init     = 1'b1;
                end
                seq_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (start_off) begin
                    if (seq_q.sw) begin
                        seq_d.iso      = 1'b1;
                        seq_d.busy     = 1'b1;
                        seq_d.going_on = 1'b0;
                        seq_d.ext      = mode_ext;
                        m_rewind       = 1'b1;
                        t_load         = 1'b1;
                        t_val          = CNT_W'(LEAD_US);
                        seq_d.st       = ST_LEAD_W;
                    end else begin
                        seq_d.done = 1'b1;
                    end
                end else if (start_on) begin
                    if (!seq_q.sw) begin
                        seq_d.sw       = 1'b1;
                        seq_d.busy     = 1'b1;
                        seq_d.going_on = 1'b1;
                        seq_d.ext      = mode_ext;
                        m_rewind       = 1'b1;
                        t_load         = 1'b1;
                        t_val          = CNT_W'(LEAD_US);
                        seq_d.st       = ST_LEAD_W;
                    end else begin
                        seq_d.done = 1'b1;
                    end
                end
            end
            ST_LEAD_W: begin
                if (t_exp) begin
                    m_step   = 1'b1;
                    t_load   = 1'b1;
                    t_val    = CNT_W'(STEP_US);
                    seq_d.st = ST_MEM_W;
                end
            end
            ST_MEM_W: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (m_all_done) begin
                        t_val    = CNT_W'(TAIL_US);
                        seq_d.st = ST_TAIL_W;
                    end else begin
                        m_step = 1'b1;
                        t_val  = CNT_W'(STEP_US);
                    end
                end
            end
            ST_TAIL_W: begin
                if (t_exp) begin
                    if (seq_q.going_on) begin
                        seq_d.rst = 1'b1;
                        seq_d.st  = ST_ON_ISO;
                    end else begin
                        seq_d.sw = 1'b0;
                        t_load   = 1'b1;
                        t_val    = CNT_W'(SW_SETTLE_US);
                        seq_d.st = ST_SWOFF_W;
                    end
                end
            end
            ST_SWOFF_W: begin
                if (t_exp) begin
                    seq_d.clka = 1'b0;
                    seq_d.st   = ST_CLKB_OFF;
                end
            end
            ST_CLKB_OFF: begin
                seq_d.clkb = 1'b0;
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.st   = ST_IDLE;
            end
            ST_ON_ISO: begin
                seq_d.iso = 1'b0;
                seq_d.st  = ST_ON_UNRST;
            end
            ST_ON_UNRST: begin
                seq_d.rst = 1'b0;
                seq_d.st  = ST_ON_CLKA;
            end
            ST_ON_CLKA: begin
                seq_d.clka = 1'b1;
                seq_d.st   = ST_ON_CLKB;
            end
            ST_ON_CLKB: begin
                seq_d.clkb = 1'b1;
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
                seq_d.st   = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st       <= ST_INIT;
            seq_q.going_on <= 1'b0;
            seq_q.ext      <= 1'b0;
            seq_q.iso      <= 1'b1;
            seq_q.sw       <= 1'b0;
            seq_q.rst      <= 1'b0;
            seq_q.clka     <= 1'b0;
            seq_q.clkb     <= 1'b0;
            seq_q.busy     <= 1'b0;
            seq_q.done     <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign iso_en  = seq_q.iso;
    assign sw_on   = seq_q.sw;
    assign dom_rst = seq_q.rst;
    assign clka_en = seq_q.clka;
    assign clkb_en = seq_q.clkb;
    assign busy    = seq_q.busy;
    assign done    = seq_q.done;
    assign powered = seq_q.sw;
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
    parameter int PD_W  = 96,
    parameter int AUX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iso_en,
    input logic             sw_on,
    input logic             dom_rst,
    input logic             clka_en,
    input logic             clkb_en,
    input logic [PD_W-1:0]  mem_pd,
    input logic [AUX_W-1:0] mem_pd_aux,
    input logic             busy,
    input logic             done
);
    // R3 / R5: during a sequence at most one group (two bits) changes per edge
    assert_one_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            ($countones({mem_pd, mem_pd_aux} ^ $past({mem_pd, mem_pd_aux})) <= 2));

    // R3: sequenced memory changes happen only behind isolation
    assert_mem_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && ({mem_pd, mem_pd_aux} != $past({mem_pd, mem_pd_aux}))) |-> iso_en);

    // R6: the switch opens only while isolation is on
    assert_sw_off_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_on) |-> iso_en);

    // R8: isolation is released in a sequence only while reset holds the domain
    assert_iso_release_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(iso_en) && $past(busy)) |-> dom_rst);

    // R8: second clock enable rises only once the first is already on
    assert_clk_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkb_en) |-> clka_en);

    // R8: clocks start only with isolation and reset released
    assert_clk_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clka_en) |-> (!iso_en && !dom_rst));

    // R11: a done pulse lasts one cycle and never overlaps busy
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pwr_domain_seq pds_checker #(
    .PD_W  (PD_W),
    .AUX_W (AUX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_en     (iso_en),
    .sw_on      (sw_on),
    .dom_rst    (dom_rst),
    .clka_en    (clka_en),
    .clkb_en    (clkb_en),
    .mem_pd     (mem_pd),
    .mem_pd_aux (mem_pd_aux),
    .busy       (busy),
    .done       (done)
);

// File: tb/pwr_domain_seq_tb_top.sv
module pwr_domain_seq_tb_top;
    localparam int D   = 2;    // cycles per microsecond at 2 MHz
    localparam int VW  = 112;

    typedef logic [VW-1:0] vec_t;
    typedef struct {
        int unsigned cyc;
        vec_t        v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_init = 1'b0;
    logic        mode_ext = 1'b0;
    logic        start_on = 1'b0;
    logic        start_off = 1'b0;
    logic        iso_en, sw_on, dom_rst, clka_en, clkb_en, busy, done, powered;
    logic [95:0] mem_pd;
    logic [7:0]  mem_pd_aux;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    exp_t        sbq[$];
    vec_t        last_v;

    logic        e_sw, e_iso, e_rst, e_ca, e_cb, e_busy, e_done;
    logic [95:0] e_pd;
    logic [7:0]  e_aux;

    always #2 clk = ~clk;   // 250 MHz

    pwr_domain_seq #(
        .CLK_FREQ_HZ (2_000_000)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_init   (pwr_init),
        .mode_ext   (mode_ext),
        .start_on   (start_on),
        .start_off  (start_off),
        .iso_en     (iso_en),
        .sw_on      (sw_on),
        .dom_rst    (dom_rst),
        .clka_en    (clka_en),
        .clkb_en    (clkb_en),
        .mem_pd     (mem_pd),
        .mem_pd_aux (mem_pd_aux),
        .busy       (busy),
        .done       (done),
        .powered    (powered)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic vec_t cur_vec();
        return {powered, done, busy, clkb_en, clka_en, dom_rst, iso_en, sw_on, mem_pd_aux, mem_pd};
    endfunction

    function automatic vec_t exp_vec();
        return {e_sw, e_done, e_busy, e_cb, e_ca, e_rst, e_iso, e_sw, e_aux, e_pd};
    endfunction

    task automatic model_off_state();
        e_sw = 0; e_iso = 1; e_rst = 0; e_ca = 0; e_cb = 0;
        e_busy = 0; e_done = 0; e_pd = '1; e_aux = '1;
    endtask

    task automatic push(input int unsigned c, input string tag);
        exp_t it;
        it.cyc = c;
        it.v   = exp_vec();
        it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: pops an expected item for each observed output change
    always @(negedge clk) begin
        if (!rst_n) begin
            last_v = cur_vec();
        end else begin
            while (sbq.size() > 0 && sbq[0].cyc < cyc) begin
                exp_t m;
                m = sbq.pop_front();
                checks++;
                errors++;
                $display("FAIL %s: expected change at cycle %0d not seen, now %h, expected %h",
                         m.tag, m.cyc, cur_vec(), m.v);
            end
            if (cur_vec() != last_v) begin
                if (sbq.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R10: unexpected change at cycle %0d, got %h, expected %h",
                             cyc, cur_vec(), last_v);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    checks++;
                    if (it.cyc != cyc || it.v != cur_vec()) begin
                        errors++;
                        $display("FAIL %s: cycle %0d value %h, expected cycle %0d value %h",
                                 it.tag, cyc, cur_vec(), it.cyc, it.v);
                    end
                end
                last_v = cur_vec();
            end
        end
    end

    task automatic check(input bit ok, input string tag, input vec_t got, input vec_t expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h, expected %h", tag, got, expv);
        end
    endtask

    task automatic start_pulse(input bit on, input bit off, input bit ext, output int unsigned e0);
        @(negedge clk); #1;
        start_on = on; start_off = off; mode_ext = ext;
        e0 = cyc + 1;
    endtask

    task automatic end_pulse(input bit flip_mode);
        @(negedge clk); #1;
        start_on = 0; start_off = 0;
        if (flip_mode) mode_ext = ~mode_ext;   // R4: ignored after start
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic run_off(input bit ext, input bit both);
        int unsigned t;
        int nb;
        nb = ext ? 3 : 2;
        start_pulse(both, 1'b1, ext, t);
        e_iso = 1; e_busy = 1; push(t, both ? "R13" : "R2");
        t += 20 * D;
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < 16; p++) begin
                e_pd[b*32 + 2*p +: 2] = 2'b11;
                push(t, (b == 2) ? "R4" : ((b == 0 && p == 0) ? "R2 R12" : "R3"));
                t += 5 * D;
            end
        end
        for (int k = 0; k < 8; k++) begin
            e_aux[k] = 1'b1; push(t, "R5"); t += 5 * D;
        end
        t += 20 * D;
        e_sw = 0; push(t, "R6");
        t += 20000 * D;
        e_ca = 0; push(t, "R6");
        t += 1;
        e_cb = 0; e_busy = 0; e_done = 1; push(t, "R6");
        t += 1;
        e_done = 0; push(t, "R6");
        end_pulse(1'b1);
        wait_until(t + 3);
    endtask

    task automatic run_on(input bit ext, input bit poke);
        int unsigned t;
        int nb;
        int err0;
        nb = ext ? 3 : 2;
        start_pulse(1'b1, 1'b0, ext, t);
        e_sw = 1; e_busy = 1; push(t, "R7");
        t += 20 * D;
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < 16; p++) begin
                e_pd[b*32 + 2*p +: 2] = 2'b00;
                push(t, (b == 2) ? "R4" : ((b == 0 && p == 0) ? "R7 R12" : "R7"));
                t += 5 * D;
            end
        end
        for (int k = 0; k < 8; k++) begin
            e_aux[k] = 1'b0; push(t, "R7"); t += 5 * D;
        end
        t += 20 * D;
        e_rst = 1; push(t, "R8"); t += 1;
        e_iso = 0; push(t, "R8"); t += 1;
        e_rst = 0; push(t, "R8"); t += 1;
        e_ca = 1;  push(t, "R8"); t += 1;
        e_cb = 1; e_busy = 0; e_done = 1; push(t, "R8"); t += 1;
        e_done = 0; push(t, "R8");
        end_pulse(1'b1);
        err0 = errors;
        if (poke) begin
            repeat (30) @(negedge clk);
            #1; start_on = 1; start_off = 1;   // R10: both ignored while busy
            @(negedge clk); #1; start_on = 0; start_off = 0;
        end
        wait_until(t + 3);
        if (poke) check(errors == err0, "R10", cur_vec(), exp_vec());
    endtask

    task automatic same_state(input bit on);
        int unsigned t;
        start_pulse(on, !on, 1'b0, t);
        e_done = 1; push(t, "R11");
        e_done = 0; push(t + 1, "R11");
        end_pulse(1'b0);
        wait_until(t + 4);
    endtask

    initial begin
        model_off_state();
        repeat (4) @(negedge clk);
        check(cur_vec() == exp_vec(), "R1", cur_vec(), exp_vec());   // reset state
        #1; rst_n = 1;
        repeat (3) @(negedge clk);
        check(cur_vec() == exp_vec(), "R1", cur_vec(), exp_vec());   // stays off

        same_state(1'b0);          // off while off
        run_on(1'b0, 1'b1);        // base mode, busy poke
        check(powered == sw_on && powered == 1'b1, "R9", {111'b0, powered}, {111'b0, 1'b1});
        run_off(1'b0, 1'b0);       // base mode, bank 2 untouched
        run_on(1'b1, 1'b0);        // extended mode
        same_state(1'b1);          // on while on
        run_off(1'b1, 1'b1);       // extended, both starts: off wins
        check(powered == 1'b0, "R9", {111'b0, powered}, 112'b0);

        // reset with the domain already powered
        @(negedge clk); #1;
        rst_n = 0; pwr_init = 1;
        repeat (3) @(negedge clk);
        model_off_state();
        #1; rst_n = 1;
        e_sw = 1; e_iso = 0; e_ca = 1; e_cb = 1; e_pd = '0; e_aux = '0;
        push(cyc + 1, "R1");
        repeat (4) @(negedge clk);
        #1; pwr_init = 0;
        same_state(1'b1);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R12", vec_t'(sbq.size()), '0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, got cycle %0d, expected under 190000", cyc);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule